// File: doc/BRIEF.md
# Slow-to-Fast Pulse-Per-Cycle Synchronizer

This block moves an N-bit value from a slow I/O-clock domain into a fast system-clock domain. It gives two outputs. The first is the value itself, re-timed through a chain of flops in the system domain. The second is a pulse version of the value. This output carries the value for exactly one system-clock cycle in each I/O-clock cycle where the value is non-zero, and it is all zeros at every other time.

The I/O clock enters the block as an ordinary signal. The block synchronizes it in the system domain and compares it with a delayed copy to find where each I/O period lies. That detected edge sets the single cycle in which the pulse is loaded. A value held over several I/O cycles therefore gives one pulse per I/O cycle. Repeats are not merged into one pulse. Downstream logic in the fast domain can treat each pulse as one slow-domain event.

The edge used as the strobe is a parameter. The default is the falling edge, in the middle of the I/O period, where the data has had half a period to settle through its own synchronizer.

Top module: `s2f_pulse_sync`

## Requirements
- R1: `sync_dout` equals `din` once `din` has been stable for more than `SYNC_STAGES` system-clock cycles.
- R2: In every I/O-clock cycle whose value is non-zero, `pulse_dout` carries that exact value for exactly one system-clock cycle.
- R3: A value held over consecutive I/O-clock cycles produces a separate one-cycle pulse in each of those cycles, not a single merged pulse.
- R4: `pulse_dout` is all zeros in every system-clock cycle that does not hold a pulse, and an I/O cycle whose value is zero produces no pulse.
- R5: With the default falling-edge strobe, each pulse lands inside the same I/O-clock period that carried its value, before the next rising edge of the I/O clock.
- R6: While `rst_n` is low at a rising system-clock edge, both outputs are zero from the next edge on. The synchronizer and edge history are cleared, so releasing reset produces no spurious pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Fast system clock; all flops use its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk_sys |
| clk_io | input | 1 | Slow I/O clock, sampled as data |
| din | input | WIDTH | Value launched from the I/O-clock domain |
| sync_dout | output | WIDTH | Value re-timed into the system-clock domain |
| pulse_dout | output | WIDTH | Value for one system-clock cycle per non-zero I/O cycle, zero otherwise |

## Verification
The assertions take three things for granted about the inputs:
- the system clock runs at least twice as fast as the I/O clock;
- `din` changes only just after a rising I/O-clock edge and then stays stable for the whole I/O period;
- `rst_n` is driven from the system-clock domain.

Under those conditions the detected strobes are at least two cycles apart, and every pulse follows a strobe. The stimulus drives an I/O clock twelve system cycles long at an unrelated phase. It updates `din` one nanosecond after each rising I/O edge and holds it until the next one. Random runs of repeated values, zeros and directed patterns (all-ones, single bits, runs of two and three) all stay inside that envelope.

// File: rtl/s2f_pkg.sv
// Package: shared types for the slow-to-fast pulse synchronizer.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package s2f_pkg;

    // Which detected I/O-clock edge opens the one-cycle pulse window.
    typedef enum logic {
        STROBE_ON_RISE = 1'b0,
        STROBE_ON_FALL = 1'b1
    } strobe_edge_e;

    // Smallest synchronizer depth the block accepts.
    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/s2f_sync_chain.sv
// Module: flop chain that re-times a WIDTH-bit signal into clk.
// Assumes: the input is a level that is stable for several clk cycles;
// STAGES >= 2. Reset is synchronous and active low.
module s2f_sync_chain #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the sampled input one stage further on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/s2f_edge_strobe.sv
// Module: finds one edge of a slow clock in the fast domain.
// Assumes: clk runs at least twice as fast as slow_clk_i. The strobe is
// high for one clk cycle per slow period; the edge is picked by EDGE.
module s2f_edge_strobe
    import s2f_pkg::*;
#(
    parameter int unsigned  STAGES = 2,
    parameter strobe_edge_e EDGE   = STROBE_ON_FALL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk_i,
    output logic strobe_o
);

    logic slow_sync;
    logic slow_hist_q;

    s2f_sync_chain #(
        .WIDTH  (1),
        .STAGES (STAGES)
    ) u_clk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (slow_clk_i),
        .sync_o  (slow_sync)
    );

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_hist_q <= 1'b0;
        end else begin
            slow_hist_q <= slow_sync;
        end
    end

    generate
        if (EDGE == STROBE_ON_RISE) begin : g_rise
            assign strobe_o = slow_sync & ~slow_hist_q;
        end else begin : g_fall
            assign strobe_o = ~slow_sync & slow_hist_q;
        end
    endgenerate

    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R3

endmodule

// File: rtl/s2f_pulse_gen.sv
// Module: loads the synchronized value into the pulse output for the
// single cycle after a strobe and clears it otherwise.
// Assumes: strobes are at least two cycles apart.
module s2f_pulse_gen #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] pulse_o
);

    logic [WIDTH-1:0] pulse_q;

    // Capture the value on a strobe and return to zero on every other cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if (strobe_i) begin
            pulse_q <= data_i;
        end else begin
            pulse_q <= '0;
        end
    end

    assign pulse_o = pulse_q;

    AST_PULSE_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> pulse_o == $past(data_i)); // R2
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o != '0) |=> (pulse_o == '0)); // R2
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> (pulse_o == '0)); // R4

endmodule

// File: rtl/s2f_pulse_sync.sv
// Module: top of the slow-to-fast pulse-per-cycle synchronizer.
// Assumes: clk_sys is at least twice the clk_io frequency; din is
// launched just after a rising clk_io edge and then held for the whole
// I/O period; rst_n is synchronous to clk_sys and active low.
module s2f_pulse_sync
    import s2f_pkg::*;
#(
    parameter int unsigned  WIDTH       = 5,
    parameter int unsigned  SYNC_STAGES = 2,
    parameter strobe_edge_e STROBE_EDGE = STROBE_ON_FALL
) (
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             clk_io,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync_dout,
    output logic [WIDTH-1:0] pulse_dout
);

    localparam int unsigned STAGES_USED =
        (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

    logic [WIDTH-1:0] data_sync;
    logic             io_strobe;

    s2f_sync_chain #(
        .WIDTH  (WIDTH),
        .STAGES (STAGES_USED)
    ) u_data_sync (
        .clk     (clk_sys),
        .rst_n   (rst_n),
        .async_i (din),
        .sync_o  (data_sync)
    );

    s2f_edge_strobe #(
        .STAGES (STAGES_USED),
        .EDGE   (STROBE_EDGE)
    ) u_edge (
        .clk        (clk_sys),
        .rst_n      (rst_n),
        .slow_clk_i (clk_io),
        .strobe_o   (io_strobe)
    );

    s2f_pulse_gen #(
        .WIDTH (WIDTH)
    ) u_pulse (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .strobe_i (io_strobe),
        .data_i   (data_sync),
        .pulse_o  (pulse_dout)
    );

    assign sync_dout = data_sync;

    AST_RESET_CLEARS: assert property (@(posedge clk_sys)
        !rst_n |=> (pulse_dout == '0 && sync_dout == '0)); // R6

endmodule

// File: tb/s2f_pulse_sync_tb_top.sv
`timescale 1ns/100ps
module s2f_pulse_sync_tb_top;

    localparam int W = 5;

    logic         clk_sys = 1'b0;
    logic         clk_io  = 1'b0;
    logic         rst_n   = 1'b0;
    logic [W-1:0] din     = '0;
    logic [W-1:0] sync_dout;
    logic [W-1:0] pulse_dout;

    int tests  = 0;
    int fails  = 0;
    int pulse_cnt = 0;
    logic [W-1:0] pulse_val = '0;
    logic [W-1:0] prev_v = '0;
    logic         prev_nz = 1'b0;
    logic         done = 1'b0;

    s2f_pulse_sync #(.WIDTH(W)) dut_i (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .clk_io     (clk_io),
        .din        (din),
        .sync_dout  (sync_dout),
        .pulse_dout (pulse_dout)
    );

    // 200 MHz system clock.
    always #2.5 clk_sys = ~clk_sys;

    // I/O clock: 60 ns period, phase unrelated to clk_sys.
    initial begin
        #1.3;
        forever begin
            clk_io = 1'b1;
            #30;
            clk_io = 1'b0;
            #30;
        end
    end

    function automatic logic [W-1:0] expect_pulse(input logic [W-1:0] v);
        return v;
    endfunction

    function automatic int expect_count(input logic [W-1:0] v);
        return (v != '0) ? 1 : 0;
    endfunction

    task automatic check(input string req, input bit ok,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor pulse output away from the active edge.
    always @(negedge clk_sys) begin
        if (rst_n) begin
            if (pulse_dout != '0) begin
                pulse_cnt++;
                pulse_val = pulse_dout;
                check("R2 width", !prev_nz, pulse_dout, '0);
            end
            prev_nz = (pulse_dout != '0);
        end else begin
            prev_nz = 1'b0;
        end
    end

    // One I/O cycle: close out the previous cycle, then launch value v.
    task automatic io_cycle(input logic [W-1:0] v);
        @(posedge clk_io);
        // R3 R4 R5: previous cycle saw exactly its own pulse count.
        check("R4 count", pulse_cnt == expect_count(prev_v),
              W'(pulse_cnt), W'(expect_count(prev_v)));
        if (prev_v != '0)
            check("R3 R5 value", pulse_val == expect_pulse(prev_v),
                  pulse_val, prev_v);
        pulse_cnt = 0;
        pulse_val = '0;
        #1 din = v;
        prev_v = v;
        #20;
        check("R1 sync", sync_dout == v, sync_dout, v);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        // R6: outputs zero during reset while the I/O clock runs.
        din = 5'h1B;
        repeat (12) @(posedge clk_sys);
        @(negedge clk_sys);
        check("R6 reset sync", sync_dout == '0, sync_dout, '0);
        check("R6 reset pulse", pulse_dout == '0, pulse_dout, '0);
        din = '0;
        rst_n = 1'b1;
        prev_v = '0;
        pulse_cnt = 0;

        // Directed: zero, rise to value, held 2 and 3 cycles, corners.
        io_cycle('0);
        io_cycle(5'h03);
        io_cycle('0);
        io_cycle(5'h11);
        io_cycle(5'h11);            // R3 held two cycles
        io_cycle('0);
        io_cycle(5'h1F);
        io_cycle(5'h1F);
        io_cycle(5'h1F);            // R3 held three cycles
        for (int b = 0; b < W; b++) io_cycle(W'(1) << b);
        io_cycle('0);
        io_cycle('0);               // R4 zero gives no pulse

        // Random runs of repeated values and zeros.
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] v;
            int run;
            v = ($urandom % 10 < 3) ? '0 : W'($urandom);
            run = 1 + ($urandom % 4);
            for (int r = 0; r < run; r++) io_cycle(v);
        end

        // R6: reset mid-stream with a held value, then clean restart.
        io_cycle(5'h0A);
        @(posedge clk_io);
        pulse_cnt = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk_sys);
        @(negedge clk_sys);
        check("R6 mid reset sync", sync_dout == '0, sync_dout, '0);
        check("R6 mid reset pulse", pulse_dout == '0, pulse_dout, '0);
        din = '0;
        repeat (14) @(posedge clk_sys);
        @(negedge clk_sys);
        rst_n = 1'b1;
        prev_v = '0;
        pulse_cnt = 0;
        io_cycle(5'h07);
        io_cycle(5'h07);
        io_cycle('0);
        io_cycle('0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule